// File: doc/BRIEF.md
# Block-RAM Style Memory with Sequential Clear

This block is a single-port memory whose storage is written in a form that an on-chip block RAM can absorb: the array has no reset path, and every access to it sits in its own clocked process. Because such a RAM cannot be wiped in one cycle, the block clears itself after a logic reset. A counter walks the array from the lowest address to the highest and writes zero to one location on each clock. It raises `ready` only when the walk is complete.

Reads are fully synchronous. A read happens on every clock while the block is ready. The memory captures the address on one edge, and `rdata` presents the word on the following edge. A consumer that drives an address in cycle t therefore samples the data in cycle t+2. While `ready` is low, both writes and reads are dropped and `rdata` holds its last value. The parameter `CLEAR_EN` can turn the sweep off. In that mode the contents are left as they were across a reset, and `ready` returns one cycle after reset.

Top module: `sweep_ram`

## Requirements
- R1: `rst` is synchronous and active high. While `rst` is high, `ready` reads 0. With `CLEAR_EN`=1, `ready` stays 0 for exactly DEPTH clock cycles after the last edge at which `rst` was high, and then reads 1.
- R2: After a completed sweep, every address from 0 to DEPTH-1 reads back as zero.
- R3: A read issued by driving `addr` in cycle t (with `we`=0 and `ready`=1) shows the stored word on `rdata` in cycle t+2 and not earlier. Back-to-back reads stream one word per cycle.
- R4: With `ready`=1, a write (`we`=1) stores `wdata` at `addr` on that clock edge, and a later read returns it.
- R5: A read that shares a cycle and address with a write returns the contents from before the write (read-first). The next read returns the new data.
- R6: A write presented while `ready` is 0 is dropped and changes no location.
- R7: While `ready` is 0, reads are dropped and `rdata` keeps its previous value, including during a clear sweep.
- R8: With `CLEAR_EN`=0, `ready` is 1 from the first cycle after `rst` falls, and reset leaves the stored contents unchanged.
- R9: A reset asserted during a sweep restarts the sweep from address 0. `ready` then stays low for a full DEPTH cycles after that reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the control logic (not of the array) |
| we | input | 1 | Write enable, honoured only while ready is 1 |
| addr | input | AW = clog2(DEPTH) | Address for both reads and writes |
| wdata | input | WIDTH | Data to be written |
| rdata | output | WIDTH | Read data, valid two cycles after its address |
| ready | output | 1 | High when user accesses are accepted; low during reset and clearing |

## Verification
The checks that run on every cycle cover the following:
- No user write reaches the array while `ready` is low.
- The sweep address rises by one per cycle, and `ready` is low during the sweep.
- `ready` rises right after the last address is written.
- `rdata` stays frozen whenever a read was refused.
- In the no-clear configuration, `ready` returns right after reset.

Some properties depend on data values and only the bench scenarios can show them:
- every location is zero after a sweep;
- the exact two-cycle read latency;
- the read-first ordering on a same-address write;
- a write dropped during the sweep has left no trace;
- a mid-sweep reset costs a full DEPTH cycles;
- contents survive reset in the no-clear configuration.

// File: rtl/sweep_ram.sv
module sweep_ram #(
  parameter int DEPTH = 2048,
  parameter int WIDTH = 16,
  parameter bit CLEAR_EN = 1'b1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             ready
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] mem_q;
  logic             clearing;
  logic [AW-1:0]    clr_addr;
  logic             rd_v;

  wire              acc        = ready & ~rst;
  wire              sweep_we   = clearing & ~rst;
  wire              port_we    = sweep_we | (acc & we);
  wire [AW-1:0]     port_addr  = sweep_we ? clr_addr : addr;
  wire [WIDTH-1:0]  port_wdata = sweep_we ? '0 : wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      clearing <= CLEAR_EN;
      clr_addr <= '0;
      ready    <= 1'b0;
    end else if (clearing) begin
      if (clr_addr == AW'(DEPTH - 1)) begin
        clearing <= 1'b0;
        ready    <= 1'b1;
      end else begin
        clr_addr <= clr_addr + 1'b1;
      end
    end else begin
      ready <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) mem_q <= mem[port_addr];
    if (port_we) mem[port_addr] <= port_wdata;
  end

  always_ff @(posedge clk) begin
    rd_v <= acc;
    if (rd_v) rdata <= mem_q;
  end

endmodule

module sweep_ram_chk #(
  parameter int DEPTH = 2048,
  parameter int WIDTH = 16,
  parameter bit CLEAR_EN = 1'b1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             ready,
  input logic [WIDTH-1:0] rdata,
  input logic             sweep_we,
  input logic             port_we,
  input logic [AW-1:0]    clr_addr
);

  // R6
  busy_write_chk: assert property (@(posedge clk) disable iff (rst)
    (port_we && !sweep_we) |-> ready);

  // R1
  sweep_busy_chk: assert property (@(posedge clk) disable iff (rst)
    sweep_we |-> !ready);

  // R1
  sweep_step_chk: assert property (@(posedge clk) disable iff (rst)
    (sweep_we && clr_addr != '0) |-> clr_addr == AW'($past(clr_addr) + 1'b1));

  // R1
  sweep_done_chk: assert property (@(posedge clk) disable iff (rst)
    (sweep_we && clr_addr == AW'(DEPTH - 1)) |=> ready);

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready && !$isunknown(rdata)) |-> ##2 $stable(rdata));

  // R8
  dirty_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (!CLEAR_EN && $fell(rst)) |=> ready);

endmodule

bind sweep_ram sweep_ram_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CLEAR_EN(CLEAR_EN)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .rdata(rdata),
  .sweep_we(sweep_we), .port_we(port_we), .clr_addr(clr_addr)
);

// File: tb/tb_sweep_ram.sv
module tb_sweep_ram;
  localparam int D  = 64;
  localparam int D2 = 16;
  localparam int W  = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst, we, ready;
  logic [5:0]   addr;
  logic [W-1:0] wdata, rdata;
  logic         rst2, we2, ready2;
  logic [3:0]   addr2;
  logic [W-1:0] wdata2, rdata2;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  sweep_ram #(.DEPTH(D), .WIDTH(W), .CLEAR_EN(1'b1)) dut (
    .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready));

  sweep_ram #(.DEPTH(D2), .WIDTH(W), .CLEAR_EN(1'b0)) dut_dirty (
    .clk(clk), .rst(rst2), .we(we2), .addr(addr2), .wdata(wdata2), .rdata(rdata2), .ready(ready2));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int i, input int salt);
    return W'(i * 37 + salt * 101 + 5);
  endfunction

  task automatic fill(input int salt);
    for (int i = 0; i < D; i++) begin
      we = 1'b1; addr = 6'(i); wdata = pat(i, salt);
      @(negedge clk);
    end
    we = 1'b0;
  endtask

  task automatic scan(input bit zero, input int salt, input string req);
    for (int i = 0; i < D + 2; i++) begin
      if (i >= 2)
        chk(rdata === (zero ? '0 : pat(i - 2, salt)), req, int'(rdata),
            int'(zero ? '0 : pat(i - 2, salt)));
      if (i < D) addr = 6'(i);
      @(negedge clk);
    end
  endtask

  task automatic count_sweep(input string req);
    int cnt = 0;
    while (!ready && cnt < 4 * D) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == D, req, cnt, D);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    logic [W-1:0] held;
    int cnt;
    rst = 1'b1; we = 1'b0; addr = '0; wdata = '0;
    rst2 = 1'b1; we2 = 1'b0; addr2 = '0; wdata2 = '0;
    repeat (2) @(negedge clk);
    chk(ready == 1'b0, "R1 ready low in reset", int'(ready), 0);
    chk(ready2 == 1'b0, "R1 dirty ready low in reset", int'(ready2), 0);

    rst = 1'b0;
    count_sweep("R1 sweep length");
    scan(1'b1, 0, "R2 zero after sweep");

    fill(1);
    scan(1'b0, 1, "R3/R4 streamed readback");

    // R5 read-first
    we = 1'b1; addr = 6'd7; wdata = 16'hA5A5;
    @(negedge clk);
    we = 1'b0;
    @(negedge clk);
    chk(rdata == pat(7, 1), "R5 old data", int'(rdata), int'(pat(7, 1)));
    @(negedge clk);
    chk(rdata == 16'hA5A5, "R5 new data", int'(rdata), 16'hA5A5);

    // R6/R7 accesses during sweep
    addr = 6'd9;
    @(negedge clk); @(negedge clk);
    held = rdata;
    chk(held == pat(9, 1), "R4 read addr 9", int'(held), int'(pat(9, 1)));
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    cnt = 0;
    while (!ready && cnt < 4 * D) begin
      chk(rdata == held, "R7 rdata held", int'(rdata), int'(held));
      if (cnt == 40) begin we = 1'b1; addr = 6'd3; wdata = 16'hBEEF; end
      else begin we = 1'b0; addr = 6'(cnt); end
      cnt++;
      @(negedge clk);
    end
    we = 1'b0;
    chk(cnt == D, "R1 sweep length again", cnt, D);
    scan(1'b1, 0, "R6 dropped write, R2 zero");

    // R9 reset mid-sweep
    fill(2);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    count_sweep("R9 restart length");
    scan(1'b1, 0, "R9 zero after restart");

    // R8 dirty mode
    rst2 = 1'b0;
    chk(ready2 == 1'b0, "R8 ready low at release", int'(ready2), 0);
    @(negedge clk);
    chk(ready2 == 1'b1, "R8 ready next cycle", int'(ready2), 1);
    for (int i = 0; i < D2; i++) begin
      we2 = 1'b1; addr2 = 4'(i); wdata2 = pat(i, 3);
      @(negedge clk);
    end
    we2 = 1'b0;
    rst2 = 1'b1; @(negedge clk); rst2 = 1'b0;
    @(negedge clk);
    chk(ready2 == 1'b1, "R8 ready after second reset", int'(ready2), 1);
    for (int i = 0; i < D2 + 2; i++) begin
      if (i >= 2)
        chk(rdata2 === pat(i - 2, 3), "R8 contents kept", int'(rdata2), int'(pat(i - 2, 3)));
      if (i < D2) addr2 = 4'(i);
      @(negedge clk);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule